// File: doc/BRIEF.md
# NRZI Receive Decoder with Bit Unstuffing

This block sits after clock recovery in a full-speed serial bus receive path. Each time the recovered bit strobe fires, it samples one line level. It turns the stream of levels back into data bits and hunts for the synchronisation preamble that opens every packet. Once inside a packet it removes the zeros that the transmitter inserted after runs of ones, packs the surviving bits into bytes, and flags runs of ones that are too long. Downstream logic sees a byte together with a one-clock valid pulse, plus a flag that is high while a packet is being decoded.

The decoding rule compares each sampled level with the one sampled before it. An unchanged level is a data '1' and a transition is a data '0'. After an end-of-packet indication the reference level returns to the idle level '1'. The preamble is the decoded sequence 0,1,0,1,0,1,0,0, oldest bit first. The bit that follows it is the first payload bit. Payload bits arrive least significant bit first.

The control is a three-state machine:

- **HUNT** waits for the preamble.
- **DATA** collects payload bits.
- **DISCARD** ignores everything after a stuffing violation.

Its transitions are:

- **SYNC_SEEN** goes from HUNT to DATA when the last eight decoded bits match the preamble.
- **STUFF_VIOLATION** goes from DATA to DISCARD when a seventh consecutive '1' is decoded.
- **END_OF_PACKET** goes from any state to HUNT when `eop` is high.

Top module: `nrzi_unstuff_rx`

## Requirements
- R1: After reset, `byte_vld`, `stuff_err` and `pkt_active` are 0, and the reference line level is 1.
- R2: A sampled level equal to the previous sampled level decodes as data 1. A differing level decodes as data 0.
- R3: `pkt_active` rises one clock after the strobe that completes the decoded preamble 0,1,0,1,0,1,0,0 (oldest first). Until then no byte is produced, and preamble bits never appear in `byte_out`.
- R4: Payload bits fill the byte least significant bit first. The first payload bit after the preamble lands in `byte_out[0]`.
- R5: `byte_vld` is high for exactly one clock, starting one clock after the strobe carrying the eighth payload bit of a byte. `byte_out` holds that byte while `byte_vld` is high.
- R6: After six consecutive decoded 1s, the next decoded 0 is dropped and not counted as payload. Every decoded 0, including a dropped one, restarts the run count.
- R7: A seventh consecutive decoded 1 makes `stuff_err` pulse high for one clock and drops `pkt_active`. No further bytes appear until the next preamble after an end of packet.
- R8: When `eop` is high, the block returns to HUNT, drops `pkt_active`, discards any partial byte and resets the reference level to 1. `eop` wins over a strobe in the same cycle, and that strobe is ignored.
- R9: In a cycle with `bit_stb` low, `bit_in` is ignored. No byte or error follows that cycle, and the next decode compares against the last strobed level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Recovered line level (1 = idle level) |
| bit_stb | input | 1 | One-clock strobe marking a valid `bit_in` sample |
| eop | input | 1 | End-of-packet / single-ended-zero indication |
| byte_out | output | 8 | Last completed payload byte |
| byte_vld | output | 1 | One-clock pulse when `byte_out` is new |
| pkt_active | output | 1 | High while payload of a packet is being decoded |
| stuff_err | output | 1 | One-clock pulse on a seventh consecutive 1 |

## Verification
The payload patterns are chosen so that each one tells apart a different failure:

- An all-zero byte has a transition on every bit, so it separates the two decoding senses.
- A single set low bit reveals a reversed bit order.
- Alternating and mixed bytes expose a wrong shift direction.
- Bytes built from long runs of ones, including runs that cross byte boundaries, show whether inserted zeros are dropped, whether a real zero right after six ones is kept, and whether the run count restarts.

Directed sequences cover the remaining behaviour:

- an almost-matching preamble;
- a raw seven-ones run, followed by traffic that must be ignored;
- an end of packet that cuts a byte short, and one that arrives together with a strobe;
- garbage levels driven between strobes.

// File: rtl/nrzr_pkg.sv
package nrzr_pkg;

    // Receive controller states
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_DATA    = 2'd1,
        ST_DISCARD = 2'd2
    } rx_state_t;

    // Decoded preamble, oldest bit in the MSB
    localparam int          SYNC_BITS   = 8;
    localparam logic [7:0]  SYNC_CODE   = 8'b0101_0100;
    localparam int          STUFF_LIMIT = 6;
    localparam logic        IDLE_LEVEL  = 1'b1;

endpackage

// File: rtl/nrzi_level_dec.sv
module nrzi_level_dec #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic lvl_in,
    output logic dec_bit
);

    logic ref_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_lvl <= IDLE_LVL;
        end else if (clr) begin
            ref_lvl <= IDLE_LVL;
        end else if (stb) begin
            ref_lvl <= lvl_in;
        end
    end

    // No transition means one, transition means zero
    assign dec_bit = (lvl_in == ref_lvl);

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter #(
    parameter int              PAT_LEN = 8,
    parameter logic [PAT_LEN-1:0] PAT  = 8'b0101_0100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic dec_bit,
    output logic found
);

    logic [PAT_LEN-1:0] hist;
    logic [PAT_LEN-1:0] hist_nx;

    // Newest decoded bit enters at the LSB
    assign hist_nx = {hist[PAT_LEN-2:0], dec_bit};
    assign found   = stb && (hist_nx == PAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '1;
        end else if (clr) begin
            hist <= '1;
        end else if (stb) begin
            hist <= hist_nx;
        end
    end

endmodule

// File: rtl/ones_tracker.sv
module ones_tracker #(
    parameter int RUN_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic dec_bit,
    output logic at_run
);

    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

    logic [RUN_W-1:0] ones_q;

    assign at_run = (ones_q == RUN_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clr) begin
            ones_q <= '0;
        end else if (stb) begin
            if (!dec_bit) begin
                ones_q <= '0;
            end else if (!at_run) begin
                ones_q <= ones_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic              dec_bit,
    output logic [BYTE_W-1:0] byte_q,
    output logic              vld_q
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_nx;
    logic [CNT_W-1:0]  cnt_q;

    // LSB-first: new bit at the MSB, older bits move toward bit 0
    assign sh_nx = {dec_bit, sh_q[BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (clr) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else if (stb) begin
                sh_q <= sh_nx;
                if (cnt_q == LAST_IDX) begin
                    cnt_q  <= '0;
                    byte_q <= sh_nx;
                    vld_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nrzi_unstuff_rx.sv
module nrzi_unstuff_rx
    import nrzr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_stb,
    input  logic              eop,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              pkt_active,
    output logic              stuff_err
);

    rx_state_t state_q;
    rx_state_t state_nx;

    logic dec_bit;
    logic strobe_ok;
    logic hunt_stb;
    logic data_stb;
    logic sync_seen;
    logic at_run;
    logic stuff_drop;
    logic stuff_violation;
    logic shift_stb;
    logic seq_clr;

    // End of packet has priority over a strobe in the same cycle
    assign strobe_ok       = bit_stb && !eop;
    assign hunt_stb        = strobe_ok && (state_q == ST_HUNT);
    assign data_stb        = strobe_ok && (state_q == ST_DATA);
    assign stuff_drop      = data_stb && at_run && !dec_bit;
    assign stuff_violation = data_stb && at_run && dec_bit;
    assign shift_stb       = data_stb && !at_run;
    assign seq_clr         = eop || sync_seen;

    nrzi_level_dec #(
        .IDLE_LVL (IDLE_LEVEL)
    ) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (eop),
        .stb     (strobe_ok),
        .lvl_in  (bit_in),
        .dec_bit (dec_bit)
    );

    sync_hunter #(
        .PAT_LEN (SYNC_BITS),
        .PAT     (SYNC_CODE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seq_clr),
        .stb     (hunt_stb),
        .dec_bit (dec_bit),
        .found   (sync_seen)
    );

    ones_tracker #(
        .RUN_MAX (STUFF_LIMIT)
    ) u_ones (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seq_clr),
        .stb     (data_stb),
        .dec_bit (dec_bit),
        .at_run  (at_run)
    );

    byte_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seq_clr),
        .stb     (shift_stb),
        .dec_bit (dec_bit),
        .byte_q  (byte_out),
        .vld_q   (byte_vld)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (eop) begin
            state_nx = ST_HUNT;                 // END_OF_PACKET
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (sync_seen) state_nx = ST_DATA;        // SYNC_SEEN
                end
                ST_DATA: begin
                    if (stuff_violation) state_nx = ST_DISCARD; // STUFF_VIOLATION
                end
                ST_DISCARD: begin
                    state_nx = ST_DISCARD;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_active <= 1'b0;
            stuff_err  <= 1'b0;
        end else begin
            pkt_active <= (state_nx == ST_DATA);
            stuff_err  <= stuff_violation;
        end
    end

    // stuff_drop marks a bit consumed without shifting (kept for clarity)
    logic unused_drop;
    assign unused_drop = stuff_drop;

endmodule

// File: rtl/nrzi_unstuff_rx_chk.sv
module nrzi_unstuff_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic eop,
    input logic byte_vld,
    input logic pkt_active,
    input logic stuff_err
);

    // R5
    vld_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R5
    vld_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> pkt_active);

    // R7
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |=> !stuff_err);

    // R7
    err_ends_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> !pkt_active);

    // R8
    eop_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> (!pkt_active && !byte_vld && !stuff_err));

    // R9
    idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> (!byte_vld && !stuff_err));

    // R9
    idle_active_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !eop) |=> $stable(pkt_active));

    // R3
    active_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_active) |-> $past(bit_stb));

endmodule

bind nrzi_unstuff_rx nrzi_unstuff_rx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .eop        (eop),
    .byte_vld   (byte_vld),
    .pkt_active (pkt_active),
    .stuff_err  (stuff_err)
);

// File: tb/nrzi_unstuff_rx_tb_top.sv
`timescale 1ns/1ps
module nrzi_unstuff_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b1;
    logic       bit_stb = 1'b0;
    logic       eop = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       pkt_active;
    logic       stuff_err;

    always #2.5 clk = ~clk;

    nrzi_unstuff_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_stb    (bit_stb),
        .eop        (eop),
        .byte_out   (byte_out),
        .byte_vld   (byte_vld),
        .pkt_active (pkt_active),
        .stuff_err  (stuff_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Output monitor
    logic [7:0] got [0:15];
    int  ngot = 0;
    int  nerr = 0;
    int  dbl  = 0;
    logic vld_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (ngot < 16) got[ngot] = byte_out;
                ngot = ngot + 1;
                if (vld_prev) dbl = dbl + 1;
            end
            if (stuff_err) nerr = nerr + 1;
            vld_prev = byte_vld;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run did not finish, cycles %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Line encoder model
    logic lvl = 1'b1;
    int   ones = 0;
    localparam logic [7:0] PRE = 8'b0101_0100;

    task automatic strobe(input logic l);
        @(negedge clk);
        bit_in  = l;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        bit_in  = ~l;           // garbage between strobes (R9)
        repeat (2) @(negedge clk);
    endtask

    task automatic send_dec(input logic d);
        if (!d) lvl = ~lvl;
        strobe(lvl);
    endtask

    task automatic send_data(input logic d);
        send_dec(d);
        if (d) begin
            ones = ones + 1;
            if (ones == 6) begin
                send_dec(1'b0);
                ones = 0;
            end
        end else begin
            ones = 0;
        end
    endtask

    task automatic send_sync();
        ones = 0;
        for (int i = 7; i >= 0; i--) send_dec(PRE[i]);
    endtask

    task automatic send_eop();
        @(negedge clk);
        bit_stb = 1'b0;
        eop     = 1'b1;
        @(negedge clk);
        eop    = 1'b0;
        lvl    = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) strobe(1'b1);
    endtask

    // Vector table: [31:24] byte count, [23:0] bytes, first byte lowest
    localparam int NVEC = 6;
    localparam logic [31:0] VECS [0:NVEC-1] = '{
        {8'd1, 24'h000000},
        {8'd1, 24'h000001},
        {8'd1, 24'h0000FF},
        {8'd2, 24'h003CA5},
        {8'd2, 24'h003F7E},
        {8'd3, 24'hFFFFFF}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(byte_vld == 1'b0,   "R1 byte_vld at reset",   int'(byte_vld), 0);
        check(stuff_err == 1'b0,  "R1 stuff_err at reset",  int'(stuff_err), 0);
        check(pkt_active == 1'b0, "R1 pkt_active at reset", int'(pkt_active), 0);
        rst_n = 1'b1;
        idle(4);

        // Table walk: R2 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            int nb;
            nb   = int'(VECS[v][31:24]);
            ngot = 0;
            nerr = 0;
            send_sync();
            check(pkt_active == 1'b1, "R3 active after preamble", int'(pkt_active), 1);
            for (int b = 0; b < nb; b++)
                for (int k = 0; k < 8; k++) send_data(VECS[v][b*8 + k]);
            send_eop();
            check(pkt_active == 1'b0, "R8 inactive after eop", int'(pkt_active), 0);
            check(ngot == nb, "R6 byte count", ngot, nb);
            for (int b = 0; b < nb && b < ngot; b++)
                check(got[b] == VECS[v][b*8 +: 8], "R2 R4 R6 byte value",
                      int'(got[b]), int'(VECS[v][b*8 +: 8]));
            check(nerr == 0, "R6 no stuff error", nerr, 0);
            idle(3);
        end
        check(dbl == 0, "R5 byte_vld single cycle", dbl, 0);

        // R3: near-miss preamble (last bit 1) must not start a packet
        ngot = 0;
        for (int i = 7; i >= 1; i--) send_dec(PRE[i]);
        send_dec(1'b1);
        idle(2);
        for (int k = 0; k < 8; k++) send_dec(k[0]);
        check(pkt_active == 1'b0, "R3 no packet without preamble", int'(pkt_active), 0);
        check(ngot == 0, "R3 no byte before preamble", ngot, 0);
        send_eop();
        idle(2);

        // R7: seven ones -> error, rest ignored
        ngot = 0;
        nerr = 0;
        send_sync();
        for (int i = 0; i < 7; i++) send_dec(1'b1);
        check(nerr == 1, "R7 stuff_err pulse count", nerr, 1);
        check(pkt_active == 1'b0, "R7 active dropped", int'(pkt_active), 0);
        for (int i = 0; i < 16; i++) send_dec(i[0]);
        check(ngot == 0, "R7 no bytes after violation", ngot, 0);
        check(nerr == 1, "R7 no further errors", nerr, 1);
        send_eop();
        idle(2);

        // R8: partial byte dropped at eop
        ngot = 0;
        send_sync();
        for (int k = 0; k < 5; k++) send_data(k[0]);
        send_eop();
        idle(2);
        send_sync();
        for (int k = 0; k < 8; k++) send_data(logic'((8'hC3 >> k) & 1));
        send_eop();
        check(ngot == 1, "R8 partial byte discarded", ngot, 1);
        if (ngot >= 1) check(got[0] == 8'hC3, "R8 byte after partial", int'(got[0]), 'hC3);
        idle(2);

        // R8: eop with a strobe in the same cycle; strobe is ignored
        ngot = 0;
        send_sync();
        for (int k = 0; k < 7; k++) send_data(k[0]);
        @(negedge clk);
        eop     = 1'b1;
        bit_stb = 1'b1;
        bit_in  = lvl;          // would complete the byte as a 1
        @(negedge clk);
        eop     = 1'b0;
        bit_stb = 1'b0;
        lvl     = 1'b1;
        bit_in  = 1'b1;
        @(negedge clk);
        check(ngot == 0, "R8 strobe with eop ignored", ngot, 0);
        check(pkt_active == 1'b0, "R8 inactive after eop", int'(pkt_active), 0);
        // Reference level back at 1: preamble starting from idle decodes correctly
        send_sync();
        for (int k = 0; k < 8; k++) send_data(logic'((8'h5A >> k) & 1));
        send_eop();
        check(ngot == 1, "R8 recovery byte count", ngot, 1);
        if (ngot >= 1) check(got[0] == 8'h5A, "R8 R9 recovery byte", int'(got[0]), 'h5A);
        check(dbl == 0, "R5 byte_vld single cycle overall", dbl, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule